// File: doc/BRIEF.md
# Card Bus Byte Lane Steering Unit

This unit sits between a 16-bit removable-card host bus and a pair of byte-wide flash devices. One device of the pair holds the even bytes and the other holds the odd bytes. Each clock it samples the two active-low card enables, address bit 0, the read and write strobes and the attribute-space select. From these it works out which host data lanes are driven, which device is read or written, and whether the odd byte has to cross over to the low lane for an 8-bit host.

A second, byte-wide attribute store (card information and configuration) shares the lanes. Only its even bytes exist. The unit gives that store its own read and write strobes and never strobes the flash pair during attribute cycles. All decisions are registered, so every control output is a flop and changes exactly one clock after the sampled inputs. The read data mux and the write data mux are driven from those flops.

Top module: `lane_steer`

## Requirements
- R1: When both card enables are high (standby), one cycle later both lane enables are 0, `host_rdata` is all zeros and no read or write strobe is active, whatever the other inputs are.
- R2: With only `ce_lo_n` low and `a0`=0, a read enables the low lane only and places the even device byte on `host_rdata[7:0]`.
- R3: With only `ce_lo_n` low and `a0`=1, a read enables the low lane only and places the odd device byte on `host_rdata[7:0]`. A write in this mode strobes only the odd device, and `odd_wdata` takes `host_wdata[7:0]`.
- R4: With both card enables low (word access), `a0` is ignored. A read enables both lanes, with the odd byte on `host_rdata[15:8]` and the even byte on `host_rdata[7:0]`. A write strobes both devices, with `even_wdata`=`host_wdata[7:0]` and `odd_wdata`=`host_wdata[15:8]`.
- R5: With only `ce_hi_n` low, a read enables the high lane only and places the odd byte on `host_rdata[15:8]`. A write strobes only the odd device, with `odd_wdata`=`host_wdata[15:8]`.
- R6: With `attr_n` low, only even-byte positions (the low-enable byte with `a0`=0, or the low half of a word) assert `attr_rd`/`attr_wr`. An odd-byte position reads back the fill value 8'hFF on its lane. Odd-byte writes produce no strobe at all. No flash device strobe is active in attribute cycles.
- R7: A read needs `oe_n`=0 and `we_n`=1, and a write needs `we_n`=0. With both strobes high, no strobe and no lane is active and `host_rdata` is zero.
- R8: When `oe_n` and `we_n` are both low, the cycle is a write: write strobes follow the lane rules and both lane enables stay 0.
- R9: In common memory, write strobes reach only the device whose byte is written: the even device for the low-enable byte with `a0`=0, and both devices for a word. `even_wdata` is always `host_wdata[7:0]`.
- R10: While `rst` is high, all lane enables and strobes are 0 one cycle later. Outside reset, each control output reflects the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_lo_n | input | 1 | Low (even) byte card enable, active low |
| ce_hi_n | input | 1 | High (odd) byte card enable, active low |
| a0 | input | 1 | Byte address bit 0 |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| attr_n | input | 1 | Attribute space select, active low |
| host_wdata | input | 16 | Write data from host bus |
| even_rdata | input | 8 | Read data from even device |
| odd_rdata | input | 8 | Read data from odd device |
| attr_rdata | input | 8 | Read data from attribute store |
| host_rdata | output | 16 | Read data to host bus, zero on disabled lanes |
| lane_lo_oe | output | 1 | Drive enable for host lane 7..0 |
| lane_hi_oe | output | 1 | Drive enable for host lane 15..8 |
| even_wdata | output | 8 | Write data to even device / attribute store |
| odd_wdata | output | 8 | Write data to odd device |
| even_rd | output | 1 | Even device read strobe |
| odd_rd | output | 1 | Odd device read strobe |
| even_wr | output | 1 | Even device write strobe |
| odd_wr | output | 1 | Odd device write strobe |
| attr_rd | output | 1 | Attribute store read strobe |
| attr_wr | output | 1 | Attribute store write strobe |

## Verification
The bench walks all 64 combinations of the six control inputs twice, with different write data, so every row of the access table is covered in both spaces. The key corner cases are covered. An 8-bit odd read must cross to the low lane; a unit that skipped the crossover would show the even byte or drive the high lane. A word access with `a0`=1 must still return both bytes. Odd attribute positions must read the fill value and must not write, and a broken design would strobe the attribute store or a flash device. When both strobes are low, lanes that stayed enabled would fight the host's write data. A mid-run reset checks that the strobes collapse.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

    typedef enum logic [2:0] {
        AK_NONE,
        AK_EVEN,
        AK_ODD_LOW,
        AK_WORD,
        AK_ODD_HIGH
    } access_e;

    typedef struct packed {
        logic lo_oe;
        logic hi_oe;
        logic odd_to_low;
        logic attr_sel;
        logic even_rd;
        logic odd_rd;
        logic even_wr;
        logic odd_wr;
        logic attr_rd;
        logic attr_wr;
    } steer_t;

    localparam steer_t STEER_IDLE = '0;

    function automatic access_e classify(input logic ce_lo_n, input logic ce_hi_n,
                                         input logic a0);
        case ({ce_hi_n, ce_lo_n})
            2'b00:   return AK_WORD;
            2'b10:   return a0 ? AK_ODD_LOW : AK_EVEN;
            2'b01:   return AK_ODD_HIGH;
            default: return AK_NONE;
        endcase
    endfunction

    function automatic steer_t build(input access_e k, input logic oe_n,
                                     input logic we_n, input logic attr_n);
        steer_t s;
        logic   rd, wr, has_even, has_odd, in_attr;
        s        = STEER_IDLE;
        wr       = !we_n && (k != AK_NONE);
        rd       = !oe_n && we_n && (k != AK_NONE);
        has_even = (k == AK_EVEN) || (k == AK_WORD);
        has_odd  = (k == AK_ODD_LOW) || (k == AK_WORD) || (k == AK_ODD_HIGH);
        in_attr  = !attr_n;
        s.lo_oe      = rd && (k != AK_ODD_HIGH);
        s.hi_oe      = rd && ((k == AK_WORD) || (k == AK_ODD_HIGH));
        s.odd_to_low = (k == AK_ODD_LOW);
        s.attr_sel   = in_attr;
        s.even_rd    = rd && has_even && !in_attr;
        s.odd_rd     = rd && has_odd  && !in_attr;
        s.even_wr    = wr && has_even && !in_attr;
        s.odd_wr     = wr && has_odd  && !in_attr;
        s.attr_rd    = rd && has_even && in_attr;
        s.attr_wr    = wr && has_even && in_attr;
        return s;
    endfunction

endpackage

// File: rtl/lane_decode.sv
module lane_decode
    import lane_steer_pkg::*;
(
    input  logic   ce_lo_n,
    input  logic   ce_hi_n,
    input  logic   a0,
    input  logic   oe_n,
    input  logic   we_n,
    input  logic   attr_n,
    output steer_t steer
);
    access_e kind;

    always_comb begin
        kind  = classify(ce_lo_n, ce_hi_n, a0);
        steer = build(kind, oe_n, we_n, attr_n);
    end
endmodule

// File: rtl/steer_reg.sv
module steer_reg
    import lane_steer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  steer_t d,
    output steer_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= STEER_IDLE;
        else     q <= d;
    end
endmodule

// File: rtl/data_steer.sv
module data_steer
    import lane_steer_pkg::*;
#(
    parameter int          BYTE_W = 8,
    parameter logic [BYTE_W-1:0] FILL = '1,
    localparam int         BUS_W  = 2 * BYTE_W
) (
    input  steer_t             steer,
    input  logic [BUS_W-1:0]   host_wdata,
    input  logic [BYTE_W-1:0]  even_rdata,
    input  logic [BYTE_W-1:0]  odd_rdata,
    input  logic [BYTE_W-1:0]  attr_rdata,
    output logic [BUS_W-1:0]   host_rdata,
    output logic [BYTE_W-1:0]  even_wdata,
    output logic [BYTE_W-1:0]  odd_wdata
);
    logic [BYTE_W-1:0] lane_src [2];
    logic              lane_en  [2];

    always_comb begin
        if (steer.attr_sel) begin
            lane_src[0] = steer.odd_to_low ? FILL : attr_rdata;
            lane_src[1] = FILL;
        end else begin
            lane_src[0] = steer.odd_to_low ? odd_rdata : even_rdata;
            lane_src[1] = odd_rdata;
        end
        lane_en[0] = steer.lo_oe;
        lane_en[1] = steer.hi_oe;
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign host_rdata[g*BYTE_W +: BYTE_W] = lane_en[g] ? lane_src[g] : '0;
    end

    assign even_wdata = host_wdata[BYTE_W-1:0];
    assign odd_wdata  = steer.odd_to_low ? host_wdata[BYTE_W-1:0]
                                         : host_wdata[BUS_W-1:BYTE_W];
endmodule

// File: rtl/lane_steer.sv
module lane_steer
    import lane_steer_pkg::*;
#(
    parameter int                BYTE_W = 8,
    parameter logic [BYTE_W-1:0] FILL   = '1,
    localparam int               BUS_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_lo_n,
    input  logic              ce_hi_n,
    input  logic              a0,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              attr_n,
    input  logic [BUS_W-1:0]  host_wdata,
    input  logic [BYTE_W-1:0] even_rdata,
    input  logic [BYTE_W-1:0] odd_rdata,
    input  logic [BYTE_W-1:0] attr_rdata,
    output logic [BUS_W-1:0]  host_rdata,
    output logic              lane_lo_oe,
    output logic              lane_hi_oe,
    output logic [BYTE_W-1:0] even_wdata,
    output logic [BYTE_W-1:0] odd_wdata,
    output logic              even_rd,
    output logic              odd_rd,
    output logic              even_wr,
    output logic              odd_wr,
    output logic              attr_rd,
    output logic              attr_wr
);
    steer_t next_steer, cur_steer;

    lane_decode u_dec (
        .ce_lo_n (ce_lo_n),
        .ce_hi_n (ce_hi_n),
        .a0      (a0),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .attr_n  (attr_n),
        .steer   (next_steer)
    );

    steer_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (next_steer),
        .q   (cur_steer)
    );

    data_steer #(.BYTE_W(BYTE_W), .FILL(FILL)) u_data (
        .steer      (cur_steer),
        .host_wdata (host_wdata),
        .even_rdata (even_rdata),
        .odd_rdata  (odd_rdata),
        .attr_rdata (attr_rdata),
        .host_rdata (host_rdata),
        .even_wdata (even_wdata),
        .odd_wdata  (odd_wdata)
    );

    assign lane_lo_oe = cur_steer.lo_oe;
    assign lane_hi_oe = cur_steer.hi_oe;
    assign even_rd    = cur_steer.even_rd;
    assign odd_rd     = cur_steer.odd_rd;
    assign even_wr    = cur_steer.even_wr;
    assign odd_wr     = cur_steer.odd_wr;
    assign attr_rd    = cur_steer.attr_rd;
    assign attr_wr    = cur_steer.attr_wr;
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk (
    input logic clk,
    input logic rst,
    input logic ce_lo_n,
    input logic ce_hi_n,
    input logic oe_n,
    input logic we_n,
    input logic lane_lo_oe,
    input logic lane_hi_oe,
    input logic even_rd,
    input logic odd_rd,
    input logic even_wr,
    input logic odd_wr,
    input logic attr_rd,
    input logic attr_wr
);
    logic primed;
    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    wire any_strobe = even_rd | odd_rd | even_wr | odd_wr | attr_rd | attr_wr;

    assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        primed && $past(ce_lo_n && ce_hi_n) |-> !lane_lo_oe && !lane_hi_oe && !any_strobe);

    assert_byte_low_lane_R2: assert property (@(posedge clk) disable iff (rst)
        primed && $past(!ce_lo_n && ce_hi_n && !oe_n && we_n) |-> lane_lo_oe && !lane_hi_oe);

    assert_word_both_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        primed && $past(!ce_lo_n && !ce_hi_n && !oe_n && we_n) |-> lane_lo_oe && lane_hi_oe);

    assert_odd_only_high_R5: assert property (@(posedge clk) disable iff (rst)
        primed && $past(ce_lo_n && !ce_hi_n && !oe_n && we_n) |-> lane_hi_oe && !lane_lo_oe);

    assert_attr_isolated_R6: assert property (@(posedge clk) disable iff (rst)
        (attr_rd || attr_wr) |-> !(even_rd || odd_rd || even_wr || odd_wr));

    assert_write_lanes_off_R8: assert property (@(posedge clk) disable iff (rst)
        primed && $past(!we_n) |-> !lane_lo_oe && !lane_hi_oe);

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> !lane_lo_oe && !lane_hi_oe && !any_strobe);
endmodule

bind lane_steer lane_steer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce_lo_n    (ce_lo_n),
    .ce_hi_n    (ce_hi_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .lane_lo_oe (lane_lo_oe),
    .lane_hi_oe (lane_hi_oe),
    .even_rd    (even_rd),
    .odd_rd     (odd_rd),
    .even_wr    (even_wr),
    .odd_wr     (odd_wr),
    .attr_rd    (attr_rd),
    .attr_wr    (attr_wr)
);

// File: tb/sim_lane_steer.sv
`timescale 1ns/1ps
module sim_lane_steer;
    localparam logic [7:0] EVEN_D = 8'h5A;
    localparam logic [7:0] ODD_D  = 8'hC3;
    localparam logic [7:0] ATTR_D = 8'h3C;

    typedef struct {
        string       tag;
        logic        lo_oe, hi_oe;
        logic [15:0] rdata;
        logic [7:0]  ewd, owd;
        logic [5:0]  strobes; // even_rd odd_rd even_wr odd_wr attr_rd attr_wr
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_lo_n = 1'b1, ce_hi_n = 1'b1, a0 = 1'b0, oe_n = 1'b1, we_n = 1'b1, attr_n = 1'b1;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic lane_lo_oe, lane_hi_oe, even_rd, odd_rd, even_wr, odd_wr, attr_rd, attr_wr;
    logic [7:0] even_wdata, odd_wdata;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    bit done = 0;

    always #2 clk = ~clk;

    lane_steer u0 (
        .clk(clk), .rst(rst), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .a0(a0),
        .oe_n(oe_n), .we_n(we_n), .attr_n(attr_n), .host_wdata(host_wdata),
        .even_rdata(EVEN_D), .odd_rdata(ODD_D), .attr_rdata(ATTR_D),
        .host_rdata(host_rdata), .lane_lo_oe(lane_lo_oe), .lane_hi_oe(lane_hi_oe),
        .even_wdata(even_wdata), .odd_wdata(odd_wdata), .even_rd(even_rd),
        .odd_rd(odd_rd), .even_wr(even_wr), .odd_wr(odd_wr),
        .attr_rd(attr_rd), .attr_wr(attr_wr)
    );

    function automatic exp_t model(logic cl, logic ch, logic ad, logic oe, logic we,
                                   logic at, logic [15:0] wd);
        exp_t e;
        logic lo_act, hi_act, rd, wr, ev, od;
        lo_act = !cl; hi_act = !ch;
        rd = !oe && we && (lo_act || hi_act);
        wr = !we && (lo_act || hi_act);
        ev = lo_act && (hi_act || !ad);
        od = hi_act || (lo_act && ad);
        e.lo_oe = rd && lo_act;
        e.hi_oe = rd && hi_act;
        e.rdata = '0;
        if (e.lo_oe) e.rdata[7:0]  = !at ? (ev ? ATTR_D : 8'hFF) : (ev ? EVEN_D : ODD_D);
        if (e.hi_oe) e.rdata[15:8] = !at ? 8'hFF : ODD_D;
        e.ewd = wd[7:0];
        e.owd = (lo_act && !hi_act && ad) ? wd[7:0] : wd[15:8];
        e.strobes = {rd && ev && at, rd && od && at, wr && ev && at, wr && od && at,
                     rd && ev && !at, wr && ev && !at};
        if (!lo_act && !hi_act)      e.tag = "R1";
        else if (!oe && !we)         e.tag = "R8";
        else if (oe && we)           e.tag = "R7";
        else if (!at)                e.tag = "R6";
        else if (wr && !(lo_act && !hi_act && ad) && !(!lo_act && hi_act)) e.tag = "R9";
        else if (lo_act && hi_act)   e.tag = "R4";
        else if (hi_act)             e.tag = "R5";
        else if (ad)                 e.tag = "R3";
        else                         e.tag = "R2";
        return e;
    endfunction

    task automatic drive(logic cl, logic ch, logic ad, logic oe, logic we,
                         logic at, logic [15:0] wd);
        @(negedge clk);
        ce_lo_n = cl; ce_hi_n = ch; a0 = ad; oe_n = oe; we_n = we; attr_n = at;
        host_wdata = wd;
        @(posedge clk);
        q.push_back(model(cl, ch, ad, oe, we, at, wd));
    endtask

    // monitor: compares outputs 1 ns after the edge that registered the item
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            logic [5:0] act;
            logic bad;
            e = q.pop_front();
            act = {even_rd, odd_rd, even_wr, odd_wr, attr_rd, attr_wr};
            bad = (lane_lo_oe !== e.lo_oe) || (lane_hi_oe !== e.hi_oe) ||
                  (host_rdata !== e.rdata) || (act !== e.strobes) ||
                  ((e.strobes[3] || e.strobes[1]) && even_wdata !== e.ewd) ||
                  (e.strobes[2] && odd_wdata !== e.owd);
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s: oe=%b%b rdata=%h str=%b ew=%h ow=%h expected oe=%b%b rdata=%h str=%b ew=%h ow=%h",
                         e.tag, lane_hi_oe, lane_lo_oe, host_rdata, act, even_wdata, odd_wdata,
                         e.hi_oe, e.lo_oe, e.rdata, e.strobes, e.ewd, e.owd);
            end
        end
    end

    task automatic check_quiet(string tag);
        checks++;
        if ({lane_lo_oe, lane_hi_oe, even_rd, odd_rd, even_wr, odd_wr, attr_rd, attr_wr} !== 8'h00) begin
            errors++;
            $display("FAIL %s: controls=%b expected 00000000", tag,
                     {lane_lo_oe, lane_hi_oe, even_rd, odd_rd, even_wr, odd_wr, attr_rd, attr_wr});
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_quiet("R10"); // reset state
        rst = 1'b0;
        // every access-table row, both spaces, two write patterns
        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < 64; v++) begin
                drive(v[5], v[4], v[3], v[2], v[1], v[0],
                      pass == 0 ? 16'hB729 : 16'h46E1);
            end
        end
        // reset in the middle of a word write: R10
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h1234);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_quiet("R10");
        rst = 1'b0;
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0);  // R5 after reset
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0);  // R3 after reset
        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule